// File: doc/BRIEF.md
# In-Place Packed-Pixel Scrambler

This block is a memory-to-memory engine. It scrambles a square image that is stored one 16-bit packed colour pixel per word in a single-port synchronous memory. A one-cycle `go` pulse starts a job. The engine then visits every pixel word of the image in ascending address order, starting at the image base.

For each word the engine does three things:
- It exchanges the two 4-bit halves inside each byte.
- It replaces the result with all-ones minus that value.
- It writes the result back over the source word.

After the last pixel it stores a zero word at a fixed end-of-job address. It then pulses `done` for one cycle.

Each pixel costs three memory cycles: a read cycle, a cycle in which the read data returns, and a write cycle. The memory is assumed to capture the address on the clock edge that ends a read cycle and to present the data during the following cycle. Only one access is made per cycle. A `go` pulse that arrives while a job is running has no effect.

Top module: `pix_crypt_engine`

## Requirements
- R1: After a synchronous active-high reset, `done`, `mem_rd_en` and `mem_wr_en` are all low, and the engine stays idle until `go`.
- R2: Within each byte of a pixel, bits [7:4] and bits [3:0] trade places, and no bit crosses from one byte into the other.
- R3: The word written is 0xFFFF minus the nibble-swapped word. Every bit is therefore inverted, and the subtraction never borrows for any input, including 0x0000 and 0xFFFF.
- R4: The result is written to the address it was read from. Every image word, from address 1024 through 1599 (24x24 = 576 words), is read once and written exactly once per job, in ascending order.
- R5: No word outside the image range is modified, apart from the end-of-job marker.
- R6: After the last pixel is written, the value 0x0000 is written to address 0xFFF.
- R7: Each pixel takes exactly three cycles. `done` is high for exactly one cycle, in the 1730th cycle after the edge that samples `go` (3x576 pixel cycles, one marker cycle, then `done`).
- R8: A `go` pulse that arrives while a job is in progress has no effect. The job neither restarts nor processes any pixel twice.
- R9: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, sampled only while idle |
| done | output | 1 | One-cycle pulse that ends a job |
| mem_addr | output | 12 | Word address for the current access |
| mem_rd_en | output | 1 | Read strobe; data returns in the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle after a read |

## Verification
The bench goes after a set of corners that each expose a specific fault:
- The all-zero and all-one pixels, plus asymmetric nibble patterns placed at the first and last image words. A datapath that swaps whole bytes or crosses nibbles between bytes writes a different word, and an XOR or a wrong-width subtraction breaks the 0x0000/0xFFFF cases.
- The words just below 1024 and just above 1599. These catch an address generator that is off by one at either end.
- A count of writes per job. This catches a missing or repeated pixel.
- `go` pulses fired in the middle of a job. Because the scramble undone twice is the identity, a restarted engine leaves words unscrambled.
- The exact cycle of `done`. This exposes a wrong read-latency assumption or a pulse that lasts more than one cycle.

// File: rtl/pix_crypt_pkg.sv
package pix_crypt_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 16;
    localparam int NIB_W     = 4;
    localparam int BYTE_W    = 2 * NIB_W;
    localparam int N_BYTES   = DATA_W / BYTE_W;

    localparam int DEF_BASE  = 1024;
    localparam int DEF_SIDE  = 24;
    localparam int DEF_END   = (1 << ADDR_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LAT,
        ST_WRITE,
        ST_MARK,
        ST_FIN
    } eng_state_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mem_req_t;

    function automatic logic [BYTE_W-1:0] swap_nibbles(input logic [BYTE_W-1:0] b);
        return {b[NIB_W-1:0], b[BYTE_W-1:NIB_W]};
    endfunction

endpackage

// File: rtl/pix_crypt_cipher.sv
module pix_crypt_cipher
    import pix_crypt_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] swapped;

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        assign swapped[b*BYTE_W +: BYTE_W] = swap_nibbles(din[b*BYTE_W +: BYTE_W]);
    end

    // Subtraction from all ones: never borrows, so equals bitwise inversion.
    assign dout = {DATA_W{1'b1}} - swapped;

    // R3: output and swapped word share no set bit and together fill the word
    always_comb begin
        a_r3_full_inversion: assert (((dout & swapped) == '0) && ((dout | swapped) == '1) || $isunknown(din));
    end

endmodule

// File: rtl/pix_crypt_addr_gen.sv
module pix_crypt_addr_gen
    import pix_crypt_pkg::*;
#(
    parameter int BASE      = DEF_BASE,
    parameter int NUM_WORDS = DEF_SIDE * DEF_SIDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (step && !last) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IDX_LAST);
    assign addr = ADDR_W'(BASE) + ADDR_W'(idx);

    // R4: index never runs past the final image word
    a_r4_idx_bounded: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_LAST);

    // R4: a step moves to the next word, one at a time
    a_r4_idx_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !last) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/pix_crypt_ctrl.sv
module pix_crypt_ctrl
    import pix_crypt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       last,
    output eng_state_e state,
    output logic       clear,
    output logic       step
);

    eng_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (go) nxt = ST_READ;
            ST_READ:  nxt = ST_LAT;
            ST_LAT:   nxt = ST_WRITE;
            ST_WRITE: nxt = last ? ST_MARK : ST_READ;
            ST_MARK:  nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    assign clear = (state == ST_IDLE) && go;
    assign step  = (state == ST_WRITE);

    // R8: once a job is running it only returns to idle through the finish state
    a_r8_no_early_idle: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_FIN) |=> (state != ST_IDLE));

    // R7: finish state lasts one cycle and follows the marker write
    a_r7_fin_after_mark: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |-> ($past(state) == ST_MARK));

endmodule

// File: rtl/pix_crypt_engine.sv
module pix_crypt_engine
    import pix_crypt_pkg::*;
#(
    parameter int IMG_BASE = DEF_BASE,
    parameter int IMG_SIDE = DEF_SIDE,
    parameter int END_ADDR = DEF_END
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IMG_WORDS = IMG_SIDE * IMG_SIDE;
    localparam int IMG_LAST  = IMG_BASE + IMG_WORDS - 1;

    eng_state_e        state;
    logic              clear;
    logic              step;
    logic              last;
    logic [ADDR_W-1:0] pix_addr;
    logic [DATA_W-1:0] enc_word;
    logic [DATA_W-1:0] enc_q;
    mem_req_t          req;

    pix_crypt_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .last  (last),
        .state (state),
        .clear (clear),
        .step  (step)
    );

    pix_crypt_addr_gen #(
        .BASE      (IMG_BASE),
        .NUM_WORDS (IMG_WORDS)
    ) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .step  (step),
        .addr  (pix_addr),
        .last  (last)
    );

    pix_crypt_cipher u_cipher (
        .din  (mem_rdata),
        .dout (enc_word)
    );

    // Read data returns during the latency cycle; capture the scrambled word there.
    always_ff @(posedge clk) begin
        if (rst) begin
            enc_q <= '0;
        end else if (state == ST_LAT) begin
            enc_q <= enc_word;
        end
    end

    always_comb begin
        req      = '0;
        req.addr = pix_addr;
        unique case (state)
            ST_READ:  req.rd = 1'b1;
            ST_WRITE: begin
                req.wr   = 1'b1;
                req.data = enc_q;
            end
            ST_MARK:  begin
                req.wr   = 1'b1;
                req.addr = ADDR_W'(END_ADDR);
                req.data = '0;
            end
            default:  ;
        endcase
    end

    assign mem_addr  = req.addr;
    assign mem_rd_en = req.rd;
    assign mem_wr_en = req.wr;
    assign mem_wdata = req.data;
    assign done      = (state == ST_FIN);

    // R9: one access per cycle
    a_r9_single_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    // R4: reads stay inside the image window
    a_r4_read_in_image: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_addr >= ADDR_W'(IMG_BASE) && mem_addr <= ADDR_W'(IMG_LAST)));

    // R4: a pixel write lands on the address read two cycles earlier
    a_r4_write_in_place: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_addr != ADDR_W'(END_ADDR)) |-> ($past(mem_rd_en, 2) && mem_addr == $past(mem_addr, 2)));

    // R6: the marker write carries zero
    a_r6_marker_zero: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_addr == ADDR_W'(END_ADDR)) |-> (mem_wdata == '0));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/pix_crypt_engine_tb_top.sv
module pix_crypt_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 1024;
    localparam int WORDS      = 576;
    localparam int LAST_A     = BASE + WORDS - 1;
    localparam int MARK_A     = 4095;
    localparam int DONE_CYC   = 3 * WORDS + 2;
    localparam int N_JOBS     = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        go;
    logic        done;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    logic [15:0] mem [4096];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          wr_count = 0;
    int          overlap  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_crypt_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .done      (done),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Single-port synchronous memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_count      <= wr_count + 1;
        end
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_rd_en && mem_wr_en) overlap <= overlap + 1;
    end

    function automatic logic [15:0] fill(input int a, input int seed);
        int v;
        v = (a * 40503 + seed * 7919 + (a >> 3) * seed) % 65536;
        if (a == BASE)   v = (seed == 0) ? 0 : (seed == 1) ? 16'h12AB : v;
        if (a == LAST_A) v = (seed == 0) ? 65535 : (seed == 1) ? 16'hF00F : v;
        if (a == BASE + 1) v = (seed == 0) ? 16'h0F00 : v;
        return 16'(v);
    endfunction

    function automatic logic [15:0] expect_enc(input logic [15:0] x);
        int hi, lo, sh, sl;
        hi = int'(x) / 256;
        lo = int'(x) % 256;
        sh = (hi % 16) * 16 + hi / 16;
        sl = (lo % 16) * 16 + lo / 16;
        return 16'(65535 - (sh * 256 + sl));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_job(input int seed, input bit busy_go);
        int cyc;
        int wr_start;
        bit seen;
        for (int a = 0; a < 4096; a++) mem[a] = fill(a, seed);
        @(negedge clk);
        wr_start = wr_count;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cyc  = 1;
        seen = done;
        while (!seen && cyc < 5000) begin
            // R8: stray go pulses during the job
            go = busy_go && (cyc % 97 == 5);
            @(negedge clk);
            go = 1'b0;
            cyc++;
            seen = done;
        end
        check("R7 done cycle", cyc, DONE_CYC);
        @(negedge clk);
        check("R7 done one cycle", {31'd0, done}, 0);
        check("R4 write count", wr_count - wr_start, WORDS + 1);
        // R2 R3 R4 R8: every image word scrambled once, in place
        for (int a = BASE; a <= LAST_A; a++)
            check("R2/R3/R4 pixel", mem[a], expect_enc(fill(a, seed)));
        // R6: marker
        check("R6 marker", mem[MARK_A], 0);
        // R5: everything else untouched
        for (int a = 0; a < 4096; a++)
            if ((a < BASE || a > LAST_A) && a != MARK_A)
                check("R5 untouched", mem[a], fill(a, seed));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        go  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and idle without go
        check("R1 done", {31'd0, done}, 0);
        check("R1 rd_en", {31'd0, mem_rd_en}, 0);
        check("R1 wr_en", {31'd0, mem_wr_en}, 0);
        repeat (5) @(negedge clk);
        check("R1 idle rd", {31'd0, mem_rd_en}, 0);
        check("R1 idle wr", {31'd0, mem_wr_en}, 0);
        for (int j = 0; j < N_JOBS; j++) run_job(j, (j % 2) == 1);
        // R9: no cycle with both strobes
        check("R9 overlap", overlap, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule